// File: doc/BRIEF.md
# Pixel-Phase Edge Generator

This block turns a fast clock running at 48 ticks per pixel period into the horizontal clocking waveforms for an image sensor readout. It makes two complementary horizontal clock pairs (`h1`/`h2` and `h3`/`h4`), a reset-gate clock (`rg`), two one-tick sample strobes (`shp` and `shd`), and a one-tick strobe (`dout_stb`) that marks where the output data word is updated. An internal phase counter gives every tick of the pixel period a position from 0 to 47.

Software programs each edge as a 6-bit position in quadrant form. A 3-bit drive code per output gives the output-enable that a pad would use to three-state the pin. Registers are loaded through a simple parallel write port. Every write goes to a staging copy, and the staging copy becomes active only at the start of the next pixel period, so no pulse is ever cut short.

Top module: `pp_edge_gen`

## Requirements
- R1: `phase_code` holds `{quad[1:0], off[3:0]}` with `off` in the range 0..11. It counts off 0..11 in each quad, then moves to the next quad. After code 59 (quad 3, off 11) it returns to code 0, so one pixel period is 48 cycles. After reset it is 0.
- R2: Linear position p is encoded as `{p/12, p%12}`. A value whose low nibble is 12..15 never matches the phase. Such an edge never happens and the affected output keeps its level. Such a strobe location never fires.
- R3: Each of the channels h1, h3 and rg has an internal level. The level becomes 1 in the cycle after `phase_code` equals the channel's rise code. It becomes 0 in the cycle after `phase_code` equals the channel's fall code. The output equals the level XOR the channel's polarity bit.
- R4: When a channel's rise and fall codes are equal, its level does not change.
- R5: `h2` is always the inverse of `h1`, and `h4` is always the inverse of `h3`.
- R6: `shp`, `shd` and `dout_stb` are each high for exactly one cycle per pixel period. The pulse comes in the cycle after `phase_code` equals that strobe's location code.
- R7: Each output has a 3-bit drive code, and its enable is high exactly when the code is nonzero. `h_oe[0..3]` belong to h1..h4.
- R8: Writes land in a staging copy. The active copy loads from the staging copy on the clock edge where `phase_code` goes from 59 to 0. Before that edge, a write has no effect on any output.
- R9: Register map, with `wr_data` bits [5:0] used:
  - Addresses 0 to 5 hold the edges: 0 is h1 rise, 1 is h1 fall, 2 is h3 rise, 3 is h3 fall, 4 is rg rise and 5 is rg fall.
  - Addresses 6, 7 and 8 hold the locations of `shp`, `shd` and `dout_stb`.
  - Address 9 holds the polarity bits {rg, h3, h1} in bits [2:0].
  - Addresses 10 to 14 hold the drive codes for h1, h2, h3, h4 and rg in bits [2:0].
  - Address 15 is ignored.
- R10: Reset clears every register, both staging and active. After reset the channel levels are 0, so `h1`, `h3` and `rg` are 0, `h2` and `h4` are 1, all enables are 0, and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 ticks per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 6 | Register write value |
| phase_code | output | 6 | Current position in quadrant form |
| h1 | output | 1 | Horizontal clock 1 |
| h2 | output | 1 | Inverse of h1 |
| h3 | output | 1 | Horizontal clock 3 |
| h4 | output | 1 | Inverse of h3 |
| rg | output | 1 | Reset-gate clock |
| shp | output | 1 | Reference sample strobe |
| shd | output | 1 | Data sample strobe |
| dout_stb | output | 1 | Output-word update strobe |
| h_oe | output | 4 | Enables for h1..h4 |
| rg_oe | output | 1 | Enable for rg |

## Verification
The main sweep steps through all 48 positions. In each step the three channels get different pulse shapes:
- h1 has a half-period pulse with normal polarity.
- h3 has an offset pulse with inverted polarity.
- rg has a one-tick pulse that crosses the wrap.

This separates off-by-one errors in the edge timing, polarity handling and decoding across the quadrant boundaries. The strobes are swept at three different offsets in the same run, so a location being swapped between strobes shows up.

Further directed cases cover:
- equal rise and fall codes;
- an invalid offset nibble on both an edge and a strobe;
- every drive code;
- a write placed mid-pixel, which separates staged loading from an immediate update.

// File: rtl/pp_edge_pkg.sv
// Package: shared widths, register addresses and the configuration record
// for the pixel-phase edge generator. Assumes four quadrants per pixel.
package pp_edge_pkg;
    localparam int QUAD_LEN  = 12;
    localparam int OFF_W     = 4;
    localparam int EDGE_W    = OFF_W + 2;
    localparam int DRV_W     = 3;
    localparam int ADDR_W    = 4;
    localparam int NUM_CH    = 3;  // h1, h3, rg
    localparam int NUM_STB   = 3;  // shp, shd, dout_stb
    localparam int NUM_DRV   = 5;  // h1, h2, h3, h4, rg

    localparam logic [ADDR_W-1:0] A_LOC0 = 4'd6;
    localparam logic [ADDR_W-1:0] A_POL  = 4'd9;
    localparam logic [ADDR_W-1:0] A_DRV0 = 4'd10;

    typedef logic [EDGE_W-1:0] edge_code_t;

    typedef struct packed {
        edge_code_t [NUM_CH-1:0]               rise;
        edge_code_t [NUM_CH-1:0]               fall;
        edge_code_t [NUM_STB-1:0]              loc;
        logic       [NUM_CH-1:0]               pol;
        logic       [NUM_DRV-1:0][DRV_W-1:0]   drv;
    } cfg_t;
endpackage

// File: rtl/pp_phase_counter.sv
// Phase counter: walks the quadrant-form position {quad, off} through one
// pixel period. Assumes QUAD_LEN fits in OFF_W bits; flags the last tick.
module pp_phase_counter #(
    parameter int QUAD_LEN = pp_edge_pkg::QUAD_LEN,
    parameter int OFF_W    = pp_edge_pkg::OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [OFF_W+1:0]   code,
    output logic               last_pos
);
    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(QUAD_LEN - 1);

    logic [1:0]       quad;
    logic [OFF_W-1:0] off;

    // Advance offset, carrying into the quadrant at the end of each quarter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quad <= '0;
            off  <= '0;
        end else if (off == OFF_MAX) begin
            off  <= '0;
            quad <= quad + 2'd1;
        end else begin
            off  <= off + 1'b1;
        end
    end

    assign code     = {quad, off};
    assign last_pos = (quad == 2'b11) && (off == OFF_MAX);

    a_r1_off_range: assert property (@(posedge clk) disable iff (!rst_n)
        off <= OFF_MAX);
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        last_pos |=> (code == '0));
endmodule

// File: rtl/pp_cfg_regs.sv
// Configuration registers: a staging copy written by the parallel port and
// an active copy loaded from it on the last tick of each pixel period.
module pp_cfg_regs
    import pp_edge_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  edge_code_t    wr_data,
    input  logic          load,
    output cfg_t          active
);
    cfg_t       staged;
    logic [1:0] loc_idx;
    logic [2:0] drv_idx;

    assign loc_idx = 2'(wr_addr - A_LOC0);
    assign drv_idx = 3'(wr_addr - A_DRV0);

    // Decode the write address into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (wr_en) begin
            if (wr_addr < A_LOC0) begin
                if (wr_addr[0]) staged.fall[wr_addr[2:1]] <= wr_data;
                else            staged.rise[wr_addr[2:1]] <= wr_data;
            end else if (wr_addr < A_POL) begin
                staged.loc[loc_idx] <= wr_data;
            end else if (wr_addr == A_POL) begin
                staged.pol <= wr_data[NUM_CH-1:0];
            end else if (wr_addr < A_DRV0 + AW'(NUM_DRV)) begin
                staged.drv[drv_idx] <= wr_data[DRV_W-1:0];
            end
        end
    end

    // Promote the staged values at the pixel boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= staged;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));
endmodule

// File: rtl/pp_edge_channel.sv
// Edge channel: holds a level that sets on the rise code and clears on the
// fall code; equal codes leave it alone. Output applies the polarity bit.
module pp_edge_channel #(
    parameter int EW       = pp_edge_pkg::EDGE_W,
    parameter int OFF_W    = pp_edge_pkg::OFF_W,
    parameter int QUAD_LEN = pp_edge_pkg::QUAD_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] code,
    input  logic [EW-1:0] rise,
    input  logic [EW-1:0] fall,
    input  logic          pol,
    output logic          wave
);
    logic lvl;
    logic match_r, match_f, rise_ok;

    assign match_r = (code == rise);
    assign match_f = (code == fall);
    assign rise_ok = (rise[OFF_W-1:0] < OFF_W'(QUAD_LEN));

    // Update the level on a single matching edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lvl <= 1'b0;
        else if (match_r && !match_f) lvl <= 1'b1;
        else if (match_f && !match_r) lvl <= 1'b0;
    end

    assign wave = lvl ^ pol;

    a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (match_r && !match_f) |=> lvl);
    a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (match_f && !match_r) |=> !lvl);
    a_r4_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rise == fall) |=> $stable(lvl));
    a_r2_invalid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_ok && !match_f) |=> $stable(lvl));
endmodule

// File: rtl/pp_strobe_gen.sv
// Strobe generator: a registered one-tick pulse in the cycle after the phase
// equals the location code. Assumes the code is held for the whole pixel.
module pp_strobe_gen #(
    parameter int EW       = pp_edge_pkg::EDGE_W,
    parameter int OFF_W    = pp_edge_pkg::OFF_W,
    parameter int QUAD_LEN = pp_edge_pkg::QUAD_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] code,
    input  logic [EW-1:0] loc,
    output logic          pulse
);
    logic loc_ok;
    assign loc_ok = (loc[OFF_W-1:0] < OFF_W'(QUAD_LEN));

    // Register the location match into the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= (code == loc);
    end

    a_r2_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(loc_ok));
endmodule

// File: rtl/pp_edge_gen.sv
// Top: pixel-phase edge generator. Ties the phase counter, staged
// configuration, three edge channels and three strobes together, builds
// the complementary clocks and derives one enable per drive code.
module pp_edge_gen
    import pp_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [EDGE_W-1:0] wr_data,
    output logic [EDGE_W-1:0] phase_code,
    output logic              h1,
    output logic              h2,
    output logic              h3,
    output logic              h4,
    output logic              rg,
    output logic              shp,
    output logic              shd,
    output logic              dout_stb,
    output logic [3:0]        h_oe,
    output logic              rg_oe
);
    logic                 last_pos;
    cfg_t                 act;
    logic [NUM_CH-1:0]    wave;
    logic [NUM_STB-1:0]   stb;
    logic [NUM_DRV-1:0]   oe;

    pp_phase_counter u_phase (
        .clk(clk), .rst_n(rst_n), .code(phase_code), .last_pos(last_pos));

    pp_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(last_pos), .active(act));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pp_edge_channel u_ch (
            .clk(clk), .rst_n(rst_n), .code(phase_code),
            .rise(act.rise[c]), .fall(act.fall[c]), .pol(act.pol[c]),
            .wave(wave[c]));
    end

    for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
        pp_strobe_gen u_stb (
            .clk(clk), .rst_n(rst_n), .code(phase_code),
            .loc(act.loc[s]), .pulse(stb[s]));
    end

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_oe
        assign oe[d] = |act.drv[d];
    end

    assign h1       = wave[0];
    assign h2       = ~wave[0];
    assign h3       = wave[1];
    assign h4       = ~wave[1];
    assign rg       = wave[2];
    assign shp      = stb[0];
    assign shd      = stb[1];
    assign dout_stb = stb[2];
    assign h_oe     = oe[3:0];
    assign rg_oe    = oe[4];

    a_r8_oe_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe) |-> $past(last_pos));
endmodule

// File: tb/pp_edge_gen_tb.sv
module pp_edge_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [5:0] phase_code;
    logic       h1, h2, h3, h4, rg, shp, shd, dout_stb, rg_oe;
    logic [3:0] h_oe;

    int checks = 0;
    int failures = 0;

    logic [5:0] b_rise [3];
    logic [5:0] b_fall [3];
    logic [5:0] b_loc  [3];
    logic [2:0] b_pol;

    always #2.5 clk = ~clk;

    pp_edge_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .phase_code(phase_code), .h1(h1), .h2(h2),
        .h3(h3), .h4(h4), .rg(rg), .shp(shp), .shd(shd),
        .dout_stb(dout_stb), .h_oe(h_oe), .rg_oe(rg_oe));

    function automatic logic [5:0] enc(int p);
        return {2'(p / 12), 4'(p % 12)};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_wr(input int a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Two wraps guarantee that every earlier write is active; ends at phase 0.
    task automatic wait_active();
        repeat (2) begin
            do @(negedge clk); while (phase_code != 6'd0);
        end
    endtask

    task automatic program_all();
        for (int c = 0; c < 3; c++) begin
            reg_wr(2 * c, b_rise[c]);
            reg_wr(2 * c + 1, b_fall[c]);
            reg_wr(6 + c, b_loc[c]);
        end
        reg_wr(9, {3'b000, b_pol});
    endtask

    // Observe two pixels from phase 0; check the second against a model (R1 R3 R5 R6 R9).
    task automatic observe();
        logic       mlvl [3];
        logic [2:0] o;
        logic [2:0] sv;
        logic [5:0] prev;
        int         cnt [3];
        prev = 6'd0;
        for (int s = 0; s < 3; s++) cnt[s] = 0;
        for (int k = 0; k < 96; k++) begin
            if (k > 0) @(negedge clk);
            o  = {rg, h3, h1};
            sv = {dout_stb, shd, shp};
            if (k == 0)
                for (int c = 0; c < 3; c++) mlvl[c] = o[c] ^ b_pol[c];
            if (k >= 48) begin
                chk(phase_code == enc(k % 48), "R1 phase", phase_code, enc(k % 48));
                for (int c = 0; c < 3; c++)
                    chk(o[c] == (mlvl[c] ^ b_pol[c]), "R3 R9 channel level",
                        o[c], mlvl[c] ^ b_pol[c]);
                chk(h2 == !h1, "R5 h2 inverse", h2, !h1);
                chk(h4 == !h3, "R5 h4 inverse", h4, !h3);
                for (int s = 0; s < 3; s++) begin
                    chk(sv[s] == (prev == b_loc[s]), "R6 strobe position",
                        sv[s], prev == b_loc[s]);
                    if (sv[s]) cnt[s]++;
                end
            end
            for (int c = 0; c < 3; c++) begin
                if (phase_code == b_rise[c] && phase_code != b_fall[c]) mlvl[c] = 1'b1;
                else if (phase_code == b_fall[c] && phase_code != b_rise[c]) mlvl[c] = 1'b0;
            end
            prev = phase_code;
        end
        for (int s = 0; s < 3; s++)
            chk(cnt[s] == ((b_loc[s][3:0] < 4'd12) ? 1 : 0), "R6 one strobe per pixel",
                cnt[s], (b_loc[s][3:0] < 4'd12) ? 1 : 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(phase_code == 6'd0, "R10 R1 reset phase", phase_code, 0);
        chk({rg, h3, h1} == 3'b000, "R10 reset levels", {rg, h3, h1}, 0);
        chk({h4, h2} == 2'b11, "R10 R5 reset complements", {h4, h2}, 3);
        chk({rg_oe, h_oe} == 5'd0, "R10 reset enables", {rg_oe, h_oe}, 0);
        chk({dout_stb, shd, shp} == 3'd0, "R10 reset strobes", {dout_stb, shd, shp}, 0);
    endtask

    // Staged write must not act before the pixel boundary (R8).
    task automatic t_staging();
        do @(negedge clk); while (phase_code != enc(20));
        reg_wr(14, 6'd5);
        @(negedge clk);
        while (phase_code != 6'd0) begin
            chk(rg_oe == 1'b0, "R8 enable before boundary", rg_oe, 0);
            @(negedge clk);
        end
        chk(rg_oe == 1'b1, "R8 enable after boundary", rg_oe, 1);
    endtask

    task automatic t_sweep();
        b_pol = 3'b110;
        for (int p = 0; p < 48; p++) begin
            b_rise[0] = enc(p);             b_fall[0] = enc((p + 24) % 48);
            b_rise[1] = enc((p + 17) % 48); b_fall[1] = enc(p);
            b_rise[2] = enc(p);             b_fall[2] = enc((p + 1) % 48);
            b_loc[0]  = enc(p);
            b_loc[1]  = enc((p + 7) % 48);
            b_loc[2]  = enc((p + 31) % 48);
            program_all();
            wait_active();
            observe();
        end
    endtask

    task automatic t_equal();
        logic v;
        reg_wr(0, enc(9));
        reg_wr(1, enc(9));
        wait_active();
        v = h1;
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            chk(h1 == v, "R4 equal codes hold", h1, v);
        end
    endtask

    task automatic t_invalid();
        reg_wr(9, 6'b000_010);   // h3 inverted
        reg_wr(2, 6'h0C);        // invalid rise
        reg_wr(3, enc(5));
        reg_wr(6, 6'h2D);        // invalid shp location
        wait_active();
        repeat (48) @(negedge clk);
        for (int k = 0; k < 48; k++) begin
            chk(h3 == 1'b1, "R2 invalid rise never fires", h3, 1);
            chk(shp == 1'b0, "R2 invalid strobe never fires", shp, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_drive();
        for (int c = 0; c < 8; c++) begin
            for (int a = 10; a < 15; a++) reg_wr(a, 6'(c));
            reg_wr(15, 6'h3F);  // ignored address
            wait_active();
            chk({rg_oe, h_oe} == ((c != 0) ? 5'h1F : 5'h00), "R7 R9 enables",
                {rg_oe, h_oe}, (c != 0) ? 31 : 0);
        end
    endtask

    initial begin
        t_reset();
        t_staging();
        t_sweep();
        t_equal();
        t_invalid();
        t_drive();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule